// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block is the digital back end of a 10-bit successive-approximation converter with a three-wire serial port. The wires are an active-low start strobe, a serial clock and a data line that can be tri-stated. A falling strobe opens a frame. The block then counts serial-clock rising edges and drives the result onto the data line one bit per edge: first leading zeros, then the ten result bits with the MSB first, then two sub-bits. The converter core supplies the result on a parallel port, and the block captures it when the frame opens.

The block has no power-control pins. Instead, it reads the edge count at the moment the strobe rises. A rise that comes early in the frame is a request to step down one power level: from normal to partial, or from partial to full. A rise after a full-length frame returns the block to normal operation. The block reports the power state, whether the reference is enabled, and whether the calibration conversion needed after power-up is still outstanding.

All control inputs are sampled on the block clock `clk_i`. An edge on the strobe or on the serial clock takes effect at the first `clk_i` rising edge that sees it, and the outputs are registered.

Top module: `sadc_out_seq`

## Requirements
- R1: After reset the data line is released (`sdo_oe_o`=0, `sdo_o`=0), `pwr_state_o`=00, `ref_en_o`=1 and `cal_pending_o`=1.
- R2: A strobe fall turns the data line on and drives it low. It also restarts the edge count and captures `result_i` and `subbits_i`.
- R3: After serial-clock rising edges 1, 2 and 3 of a frame, the data line stays low.
- R4: After rising edge k, for k from 4 to 13, the data line carries `result_i` bit 13-k. The MSB therefore appears on edge 4.
- R5: After edges 14 and 15 the line carries `subbits_i` bit 1 and then bit 0. After edge 16 it is low.
- R6: If the strobe is still low once 16 edges have passed, the line is released at the 17th serial-clock rise or at the strobe rise, whichever comes first. Once released it stays released, driving 0.
- R7: A strobe rise after 3 to 13 edges releases the line and steps the power state down one level: 00 to 01, or 01 to 10. In state 10 it stays at 10. The encoding is 00 normal, 01 partial, 10 full.
- R8: A strobe rise after 14 or more edges sets the power state to 00 from any state. After a rise at edge 14 or 15, the line keeps shifting through edge 16 and is released at the next serial-clock rise.
- R9: A strobe rise after fewer than 3 edges releases the line and leaves the power state unchanged.
- R10: `cal_pending_o` clears on the first strobe rise after 14 or more edges. Leaving a power-down state never sets it again.
- R11: `ref_en_o` is 1 in the normal and partial states and 0 in the full power-down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; samples all control inputs |
| rst_ni | input | 1 | Asynchronous active-low reset (hardware power-up) |
| start_ni | input | 1 | Active-low conversion-start strobe |
| sclk_i | input | 1 | Serial clock from the host |
| result_i | input | DATA_W | Parallel result from the converter core |
| subbits_i | input | SUB_W | Sub-bits from the converter core |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Data line drive enable (0 = high impedance) |
| pwr_state_o | output | 2 | Power state: 00 normal, 01 partial, 10 full |
| ref_en_o | output | 1 | Reference enable |
| cal_pending_o | output | 1 | Power-up calibration conversion still outstanding |

## Verification
The bench releases the strobe at edge counts on both sides of each decode boundary: 2, 3, 5, 13, 14, 16 and 17. A design whose comparator is off by one would step the power state on a full frame, or miss a request to power down. The bench also steps the state down three times in a row, to catch a design that wraps past full power-down or reaches full from normal in one step. Releasing the strobe at edge 14 checks that the remaining sub-bit is still shifted out and that the line is freed at edge 17. Several result patterns are used to catch a reversed bit order or a shifted MSB.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    PWR_NORMAL  = 2'b00,
    PWR_PARTIAL = 2'b01,
    PWR_FULL    = 2'b10
  } pwr_e;
endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= RST_VAL;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
  assign fall_o = ~d_i & d_q;
endmodule

// File: rtl/sadc_frame_shift.sv
module sadc_frame_shift #(
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2,
  parameter int LEAD_W = 3,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              strb_fall_i,
  input  logic              strb_rise_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SUB_W-1:0]  sub_i,
  output logic              sdo_o,
  output logic              oe_o,
  output logic              open_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int TOT_W       = DATA_W + SUB_W;
  localparam int EXIT_EDGES  = LEAD_W + DATA_W + 1;
  localparam int FRAME_EDGES = LEAD_W + TOT_W + 1;
  localparam logic [CNT_W-1:0] EXIT_C  = CNT_W'(EXIT_EDGES);
  localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_EDGES);
  localparam logic [CNT_W-1:0] LEAD_C  = CNT_W'(LEAD_W);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(LEAD_W + TOT_W);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(FRAME_EDGES + 1);

  logic [TOT_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sdo_q, oe_q, open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
      open_q <= 1'b0;
    end else if (strb_fall_i) begin
      sr_q   <= {data_i, sub_i};
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b1;
      open_q <= 1'b1;
    end else if (strb_rise_i && open_q) begin
      open_q <= 1'b0;
      // early rise aborts; rise at or past the frame end releases
      if (cnt_q < EXIT_C || cnt_q >= FRAME_C) begin
        oe_q  <= 1'b0;
        sdo_q <= 1'b0;
      end
    end else if (sclk_rise_i && oe_q) begin
      if (cnt_q != MAX_C) cnt_q <= cnt_q + 1'b1;
      if (cnt_q >= FRAME_C) begin
        oe_q  <= 1'b0;
        sdo_q <= 1'b0;
      end else if (cnt_q >= LEAD_C && cnt_q < LAST_C) begin
        sdo_q <= sr_q[TOT_W-1];
        sr_q  <= sr_q << 1;
      end else begin
        sdo_q <= 1'b0;
      end
    end
  end

  assign sdo_o  = sdo_q;
  assign oe_o   = oe_q;
  assign open_o = open_q;
  assign cnt_o  = cnt_q;

  // R2
  start_drive_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_fall_i |=> (oe_q && !sdo_q && cnt_q == '0));

  // R6
  late_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise_i && oe_q && cnt_q >= FRAME_C && !strb_fall_i && !strb_rise_i) |=> !oe_q);

  // R7
  abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_rise_i && open_q && cnt_q < EXIT_C) |=> (!oe_q && !open_q));

  // R6
  released_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_q && !strb_fall_i) |=> (!oe_q && !sdo_q));

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C);
endmodule

// File: rtl/sadc_pwr_ctrl.sv
module sadc_pwr_ctrl
  import sadc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LEAD_W = 3,
  parameter int CNT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strb_rise_i,
  input  logic             open_i,
  input  logic [CNT_W-1:0] cnt_i,
  output pwr_e             pwr_o,
  output logic             ref_en_o,
  output logic             cal_pending_o
);
  localparam logic [CNT_W-1:0] EXIT_C = CNT_W'(LEAD_W + DATA_W + 1);
  localparam logic [CNT_W-1:0] PD_C   = CNT_W'(LEAD_W);

  pwr_e pwr_q;
  logic cal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= PWR_NORMAL;
      cal_q <= 1'b1;
    end else if (strb_rise_i && open_i) begin
      if (cnt_i >= EXIT_C) begin
        pwr_q <= PWR_NORMAL;
        cal_q <= 1'b0;
      end else if (cnt_i >= PD_C) begin
        pwr_q <= (pwr_q == PWR_NORMAL) ? PWR_PARTIAL : PWR_FULL;
      end
    end
  end

  assign pwr_o         = pwr_q;
  assign ref_en_o      = (pwr_q != PWR_FULL);
  assign cal_pending_o = cal_q;

  // R7
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q != 2'b11);

  // R7
  no_skip_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q == PWR_NORMAL |=> pwr_q != PWR_FULL);

  // R10
  cal_sticky_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_q |=> !cal_q);

  // R9
  short_rise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_rise_i && cnt_i < PD_C) |=> $stable(pwr_q));
endmodule

// File: rtl/sadc_out_seq.sv
module sadc_out_seq
  import sadc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2,
  parameter int LEAD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [SUB_W-1:0]  subbits_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [1:0]        pwr_state_o,
  output logic              ref_en_o,
  output logic              cal_pending_o
);
  localparam int CNT_W = $clog2(LEAD_W + DATA_W + SUB_W + 3);

  logic             sclk_rise, sclk_fall_unused;
  logic             strb_rise, strb_fall;
  logic             frame_open;
  logic [CNT_W-1:0] edge_cnt;
  pwr_e             pwr;

  sadc_edge_det #(.RST_VAL(1'b0)) i_sclk_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sclk_i),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall_unused)
  );

  sadc_edge_det #(.RST_VAL(1'b1)) i_strb_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (start_ni),
    .rise_o (strb_rise),
    .fall_o (strb_fall)
  );

  sadc_frame_shift #(
    .DATA_W (DATA_W),
    .SUB_W  (SUB_W),
    .LEAD_W (LEAD_W),
    .CNT_W  (CNT_W)
  ) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_rise_i (sclk_rise),
    .strb_fall_i (strb_fall),
    .strb_rise_i (strb_rise),
    .data_i      (result_i),
    .sub_i       (subbits_i),
    .sdo_o       (sdo_o),
    .oe_o        (sdo_oe_o),
    .open_o      (frame_open),
    .cnt_o       (edge_cnt)
  );

  sadc_pwr_ctrl #(
    .DATA_W (DATA_W),
    .LEAD_W (LEAD_W),
    .CNT_W  (CNT_W)
  ) i_pwr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .strb_rise_i   (strb_rise),
    .open_i        (frame_open),
    .cnt_i         (edge_cnt),
    .pwr_o         (pwr),
    .ref_en_o      (ref_en_o),
    .cal_pending_o (cal_pending_o)
  );

  assign pwr_state_o = pwr;
endmodule

// File: tb/test_sadc_out_seq.sv
module test_sadc_out_seq;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic       sclk = 1'b0;
  logic [9:0] result = '0;
  logic [1:0] subbits = '0;
  logic       sdo, sdo_oe, ref_en, cal_pending;
  logic [1:0] pwr_state;

  always #(CLK_P/2) clk = ~clk;

  sadc_out_seq i_sadc_out_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_ni      (start_n),
    .sclk_i        (sclk),
    .result_i      (result),
    .subbits_i     (subbits),
    .sdo_o         (sdo),
    .sdo_oe_o      (sdo_oe),
    .pwr_state_o   (pwr_state),
    .ref_en_o      (ref_en),
    .cal_pending_o (cal_pending)
  );

  typedef struct {
    logic       oe;
    logic       sdo;
    logic [1:0] pwr;
    logic       cal;
    logic       ref_en;
    string      tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  // bench model of the requirements
  logic       m_oe = 0, m_sdo = 0, m_cal = 1, m_open = 0;
  logic [1:0] m_pwr = 2'b00;
  int         m_cnt = 0;
  logic [9:0] m_d = '0;
  logic [1:0] m_s = '0;

  function automatic logic ebit(int k);
    if (k >= 4 && k <= 13) return m_d[13-k];
    if (k == 14) return m_s[1];
    if (k == 15) return m_s[0];
    return 1'b0;
  endfunction

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_now(string tag);
    exp_t e;
    e.oe = m_oe; e.sdo = m_sdo; e.pwr = m_pwr; e.cal = m_cal;
    e.ref_en = (m_pwr != 2'b10); e.tag = tag;
    q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  // monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (sdo_oe !== e.oe || sdo !== e.sdo || pwr_state !== e.pwr ||
            cal_pending !== e.cal || ref_en !== e.ref_en) begin
          n_bad++;
          $display("FAIL %s: oe/sdo/pwr/cal/ref got %b %b %b %b %b expected %b %b %b %b %b",
                   e.tag, sdo_oe, sdo, pwr_state, cal_pending, ref_en,
                   e.oe, e.sdo, e.pwr, e.cal, e.ref_en);
        end
      end
    end
  end

  task automatic strobe_fall(input logic [9:0] d, input logic [1:0] s);
    result = d; subbits = s; m_d = d; m_s = s;
    start_n = 1'b0;
    settle();
    m_cnt = 0; m_open = 1; m_oe = 1; m_sdo = 0;
    expect_now("R2 strobe fall");
    result = ~d;  // captured value must be used, not the live port
  endtask

  task automatic sclk_pulse();
    int k;
    string tg;
    sclk = 1'b1;
    settle();
    k = m_cnt + 1;
    if (m_oe) begin
      if (m_cnt >= 16) begin m_oe = 0; m_sdo = 0; end
      else m_sdo = ebit(k);
      if (m_cnt < 17) m_cnt = k;
    end
    if (k <= 3) tg = "R3 lead zero";
    else if (k <= 13) tg = "R4 data bit";
    else if (k <= 16) tg = "R5 sub/trail bit";
    else tg = "R6/R8 release";
    expect_now(tg);
    sclk = 1'b0;
    settle();
  endtask

  task automatic strobe_rise(string tag);
    start_n = 1'b1;
    settle();
    if (m_open) begin
      m_open = 0;
      if (m_cnt >= 14) begin m_pwr = 2'b00; m_cal = 0; end
      else if (m_cnt >= 3) m_pwr = (m_pwr == 2'b00) ? 2'b01 : 2'b10;
      if (m_cnt < 14 || m_cnt >= 16) begin m_oe = 0; m_sdo = 0; end
    end
    expect_now(tag);
  endtask

  task automatic frame(input logic [9:0] d, input logic [1:0] s, input int n,
                       input string tag);
    strobe_fall(d, s);
    for (int i = 0; i < n; i++) sclk_pulse();
    strobe_rise(tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    settle();
    settle();
    expect_now("R1 reset state");
    rst_n = 1'b1;
    settle();
    expect_now("R1 after reset release");

    // full frame, rise after 16 edges: first conversion clears calibration
    frame(10'h2B5, 2'b10, 16, "R6 R10 rise after edge 16");
    // held low past the frame: 17th edge releases
    frame(10'h155, 2'b01, 17, "R8 rise after release");
    // short strobes step down: normal->partial->full->full
    frame(10'h3FF, 2'b11, 5, "R7 step to partial R11");
    frame(10'h000, 2'b00, 3, "R7 step to full R11");
    frame(10'h1C3, 2'b10, 13, "R7 stay in full");
    // exit at edge 14: shifting continues to edge 16, released on 17
    frame(10'h2AA, 2'b01, 14, "R8 exit at edge 14");
    for (int i = 0; i < 3; i++) sclk_pulse();
    // too-early rise leaves state alone
    frame(10'h0F0, 2'b10, 2, "R9 rise after 2 edges");
    frame(10'h0F0, 2'b10, 0, "R9 rise at once");
    // partial then exit at 15; calibration flag stays clear
    frame(10'h3A5, 2'b01, 4, "R7 to partial again");
    frame(10'h0A5, 2'b11, 15, "R8 R10 exit at edge 15");
    for (int i = 0; i < 2; i++) sclk_pulse();
    frame(10'h3C1, 2'b10, 16, "R10 normal frame");

    settle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule